// File: doc/BRIEF.md
# Compacted Multi-Entry Uop Slot Allocator

This block is the tag and placement controller of a micro-operation cache in which one physical slot can hold several entries of different sizes. Each slot of a set-associative array holds up to four sub-entries. Every sub-entry carries its own address tag, its prediction window ID, its uop count, and the offset at which its uops begin inside the slot. A lookup compares every sub-tag of the addressed set at once and returns the way, the start offset and the length of the matching entry.

An insertion first looks for a way in the set that can take the new entry without removing anything. A policy input picks which of those ways is used: the lowest index, the most recently used way, or a way that already holds an entry from the same prediction window. An existing entry is removed only when no way has room. In that case the least recently used way is emptied completely and the new entry starts at offset 0. An invalidation by address clears only the one matching sub-entry. The entries left in that slot keep their offsets.

The address splits into a set index (low bits) and a tag (the remaining bits). Placement results are shown combinationally while an insertion is requested, and the state changes on the next rising clock edge.

Top module: `uop_slot_alloc`

## Requirements
- R1: After reset every sub-entry is invalid, so a lookup of any address reports lk_hit = 0.
- R2: A lookup compares all sub-tags of set lk_addr[1:0] in the same cycle. On a match it reports lk_hit = 1 with the way, start offset and uop count of the matching entry.
- R3: A way can take a new entry only if it has a free sub-tag (at most 4 per slot) and the slot end plus the new count is at most 8. The slot end is the largest offset+count over the valid sub-entries, or 0 if there are none. The new entry is placed at that end.
- R4: With policy 0 (and the unused code 3), the lowest-indexed way that can take the entry is chosen.
- R5: With policy 1, the way with the most recent use is chosen from the ways that can take the entry. Ties go to the lowest index.
- R6: With policy 2, the lowest-indexed way that can take the entry and already holds a valid entry with the same prediction window ID is chosen. If no such way exists, the lowest-indexed way that can take it is chosen.
- R7: If no way can take the entry, ins_evict is 1. The least recently used way of the set is emptied completely, and the new entry is written there at offset 0.
- R8: An insertion, or a lookup that hits, makes its way the most recently used in its set. At reset way 0 is most recent and the highest way is least recent.
- R9: An invalidation clears only the matching sub-entry. The other entries keep their offsets. The slot end is recomputed from the entries that remain, so only space at the tail is reused.
- R10: An insertion with a count of 0 or more than 8 changes nothing. An invalidation in the same cycle as a valid insertion is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insertion request |
| ins_addr | input | 12 | Address of the new entry |
| ins_pw | input | 4 | Prediction window ID of the new entry |
| ins_cnt | input | 4 | Uop count of the new entry (1 to 8) |
| policy | input | 2 | Placement: 0 lowest way, 1 most recent, 2 same window |
| ins_way | output | 2 | Way chosen for the insertion |
| ins_offset | output | 3 | Start offset chosen for the insertion |
| ins_evict | output | 1 | Insertion needs an eviction |
| lk_valid | input | 1 | Lookup request (a hit updates recency) |
| lk_addr | input | 12 | Lookup address |
| lk_hit | output | 1 | Lookup matched a valid sub-entry |
| lk_way | output | 2 | Way of the match |
| lk_offset | output | 3 | Start offset of the match |
| lk_count | output | 4 | Uop count of the match |
| inv_valid | input | 1 | Invalidation request |
| inv_addr | input | 12 | Address to invalidate |

## Verification
The hardest situation to reach is an eviction. Every way of one set must be unable to take the entry, and the recency order must have been changed first, so that the least recently used way is not simply the last one filled. The stimulus fills all four ways of a set with full-size entries, then performs a lookup that promotes way 0. The next insertion must therefore evict way 1. The recency policy is driven in the same way: lookups reorder the ways, so that the most recently used way and the lowest feasible way are different.

// File: rtl/uop_slot_alloc.sv
module uop_slot_alloc #(
  parameter int ADDR_W    = 12,
  parameter int PW_W      = 4,
  parameter int SETS      = 4,
  parameter int WAYS      = 4,
  parameter int SUBS      = 4,
  parameter int SLOT_UOPS = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SUB_W = $clog2(SUBS),
  localparam int OFF_W = $clog2(SLOT_UOPS),
  localparam int CNT_W = $clog2(SLOT_UOPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [PW_W-1:0]   ins_pw,
  input  logic [CNT_W-1:0]  ins_cnt,
  input  logic [1:0]        policy,
  output logic [WAY_W-1:0]  ins_way,
  output logic [OFF_W-1:0]  ins_offset,
  output logic              ins_evict,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic [OFF_W-1:0]  lk_offset,
  output logic [CNT_W-1:0]  lk_count,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr
);
  logic [SUBS-1:0]  vld [SETS][WAYS];
  logic [TAG_W-1:0] tg  [SETS][WAYS][SUBS];
  logic [PW_W-1:0]  wid [SETS][WAYS][SUBS];
  logic [OFF_W-1:0] off [SETS][WAYS][SUBS];
  logic [CNT_W-1:0] cnt [SETS][WAYS][SUBS];
  logic [WAY_W-1:0] age [SETS][WAYS];

  wire [IDX_W-1:0] iset = ins_addr[IDX_W-1:0];
  wire [TAG_W-1:0] itag = ins_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] lset = lk_addr[IDX_W-1:0];
  wire [IDX_W-1:0] vset = inv_addr[IDX_W-1:0];
  wire ins_ok = ins_valid && ins_cnt != '0 && ins_cnt <= CNT_W'(SLOT_UOPS);

  function automatic logic [WAY_W+SUB_W:0] find(input logic [IDX_W-1:0] s, input logic [TAG_W-1:0] t);
    logic [WAY_W+SUB_W:0] r = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      for (int k = SUBS - 1; k >= 0; k--)
        if (vld[s][w][k] && tg[s][w][k] == t) r = {1'b1, WAY_W'(w), SUB_W'(k)};
    return r;
  endfunction

  logic [CNT_W-1:0] endp [WAYS];
  logic [SUB_W-1:0] fsub [WAYS];
  logic [WAYS-1:0]  feas, pwm, hasf;
  logic [WAY_W-1:0] pick, lru;
  logic [SUB_W-1:0] tsub;
  logic             found;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      endp[w] = '0; fsub[w] = '0; pwm[w] = 1'b0; hasf[w] = 1'b0;
      for (int k = SUBS - 1; k >= 0; k--) begin
        if (!vld[iset][w][k]) begin
          fsub[w] = SUB_W'(k); hasf[w] = 1'b1;
        end else begin
          if (CNT_W'(off[iset][w][k]) + cnt[iset][w][k] > endp[w])
            endp[w] = CNT_W'(off[iset][w][k]) + cnt[iset][w][k];
          if (wid[iset][w][k] == ins_pw) pwm[w] = 1'b1;
        end
      end
      feas[w] = hasf[w] && ({1'b0, endp[w]} + {1'b0, ins_cnt}) <= (CNT_W+1)'(SLOT_UOPS);
    end
    found = 1'b0; pick = '0; lru = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age[iset][w] == WAY_W'(WAYS - 1)) lru = WAY_W'(w);
      if (policy == 2'd1) begin
        if (feas[w] && (!found || age[iset][w] < age[iset][pick])) begin
          pick = WAY_W'(w); found = 1'b1;
        end
      end else if (policy == 2'd2) begin
        if (feas[w] && pwm[w] && !found) begin
          pick = WAY_W'(w); found = 1'b1;
        end
      end
    end
    for (int w = 0; w < WAYS; w++)
      if (policy != 2'd1 && feas[w] && !found) begin
        pick = WAY_W'(w); found = 1'b1;
      end
    ins_evict  = ins_ok && !found;
    ins_way    = found ? pick : lru;
    tsub       = found ? fsub[pick] : '0;
    ins_offset = found ? endp[pick][OFF_W-1:0] : '0;
  end

  logic [WAY_W+SUB_W:0] lres, vres;
  assign lres = find(lset, lk_addr[ADDR_W-1:IDX_W]);
  assign vres = find(vset, inv_addr[ADDR_W-1:IDX_W]);
  assign lk_hit    = lres[WAY_W+SUB_W];
  assign lk_way    = lres[WAY_W+SUB_W-1:SUB_W];
  assign lk_offset = off[lset][lk_way][lres[SUB_W-1:0]];
  assign lk_count  = cnt[lset][lk_way][lres[SUB_W-1:0]];
  wire [WAY_W-1:0] vway = vres[WAY_W+SUB_W-1:SUB_W];
  wire [SUB_W-1:0] vsub = vres[SUB_W-1:0];
  wire inv_go = !ins_ok && inv_valid && vres[WAY_W+SUB_W];
  wire lk_go  = !ins_ok && !inv_valid && lk_valid && lk_hit;

  wire [IDX_W-1:0] tset = ins_ok ? iset : lset;
  wire [WAY_W-1:0] tway = ins_ok ? ins_way : lk_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w] <= '0;
          age[s][w] <= WAY_W'(w);
        end
    end else begin
      if (ins_ok)
        vld[iset][ins_way] <= (ins_evict ? '0 : vld[iset][ins_way]) | (SUBS'(1) << tsub);
      else if (inv_go)
        vld[vset][vway][vsub] <= 1'b0;
      if (ins_ok || lk_go)
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == tway) age[tset][w] <= '0;
          else if (age[tset][w] < age[tset][tway]) age[tset][w] <= age[tset][w] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_ok) begin
      tg[iset][ins_way][tsub]  <= itag;
      wid[iset][ins_way][tsub] <= ins_pw;
      off[iset][ins_way][tsub] <= ins_offset;
      cnt[iset][ins_way][tsub] <= ins_cnt;
    end
  end

  logic             chk_go, chk_ev, chk_inv;
  logic [IDX_W-1:0] chk_set;
  logic [WAY_W-1:0] chk_way;
  logic [SUB_W-1:0] chk_sub;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_go <= 1'b0; chk_ev <= 1'b0; chk_inv <= 1'b0;
      chk_set <= '0; chk_way <= '0; chk_sub <= '0;
    end else begin
      chk_go  <= ins_ok;
      chk_ev  <= ins_evict;
      chk_inv <= inv_go;
      chk_set <= ins_ok ? iset : vset;
      chk_way <= ins_ok ? ins_way : vway;
      chk_sub <= ins_ok ? tsub : vsub;
    end
  end

  logic ages_ok, bounds_ok;
  always_comb begin
    ages_ok = 1'b1; bounds_ok = 1'b1;
    for (int s = 0; s < SETS; s++) begin
      logic [WAYS-1:0] seen;
      seen = '0;
      for (int w = 0; w < WAYS; w++) begin
        seen[age[s][w]] = 1'b1;
        for (int k = 0; k < SUBS; k++)
          if (vld[s][w][k] && ((CNT_W+1)'(off[s][w][k]) + (CNT_W+1)'(cnt[s][w][k]) > (CNT_W+1)'(SLOT_UOPS)
                               || cnt[s][w][k] == '0))
            bounds_ok = 1'b0;
      end
      if (seen != '1) ages_ok = 1'b0;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n) bounds_ok);
  p_entry_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_go |-> vld[chk_set][chk_way][chk_sub]);
  p_evict_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_go && chk_ev) |-> vld[chk_set][chk_way] == SUBS'(1));
  p_insert_mru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_go |-> age[chk_set][chk_way] == '0);
  p_age_order_r8: assert property (@(posedge clk) disable iff (!rst_n) ages_ok);
  p_inv_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_inv && !chk_go) |-> !vld[chk_set][chk_way][chk_sub]);
  p_hit_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_count != '0);
endmodule

// File: tb/uop_slot_alloc_bench.sv
module uop_slot_alloc_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, lk_valid = 0, inv_valid = 0;
  logic [11:0] ins_addr = '0, lk_addr = '0, inv_addr = '0;
  logic [3:0] ins_pw = '0, ins_cnt = '0;
  logic [1:0] policy = '0;
  logic [1:0] ins_way, lk_way;
  logic [2:0] ins_offset, lk_offset;
  logic [3:0] lk_count;
  logic ins_evict, lk_hit;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  uop_slot_alloc u_uop_slot_alloc (.*);

  function automatic logic [11:0] A(input int s, input int t);
    return 12'((t << 2) | s);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic ins(input logic [11:0] a, input int pw, input int c, input int pol,
                     input int ew, input int eo, input int ee, input string req);
    @(negedge clk);
    ins_valid = 1; ins_addr = a; ins_pw = 4'(pw); ins_cnt = 4'(c); policy = 2'(pol);
    #1;
    if (ee >= 0) chk(ins_evict == ee[0], req, "evict", int'(ins_evict), ee);
    if (ew >= 0) chk(ins_way == ew[1:0], req, "way", int'(ins_way), ew);
    if (eo >= 0) chk(ins_offset == eo[2:0], req, "offset", int'(ins_offset), eo);
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic lk(input logic [11:0] a, input int eh, input int ew, input int eo, input int ec,
                    input string req);
    @(negedge clk);
    lk_valid = 1; lk_addr = a;
    #1;
    chk(lk_hit == eh[0], req, "hit", int'(lk_hit), eh);
    if (eh != 0) begin
      chk(lk_way == ew[1:0], req, "lookup way", int'(lk_way), ew);
      chk(lk_offset == eo[2:0], req, "lookup offset", int'(lk_offset), eo);
      chk(lk_count == ec[3:0], req, "lookup count", int'(lk_count), ec);
    end
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic inv(input logic [11:0] a);
    @(negedge clk);
    inv_valid = 1; inv_addr = a;
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic t_reset_r1();
    do_reset();
    lk(A(0, 0), 0, 0, 0, 0, "R1");
    lk(A(3, 77), 0, 0, 0, 0, "R1");
  endtask

  task automatic t_pack_r3_r4();
    do_reset();
    ins(A(0, 1), 1, 3, 0, 0, 0, 0, "R4");
    ins(A(0, 2), 1, 4, 0, 0, 3, 0, "R3");
    ins(A(0, 3), 1, 2, 0, 1, 0, 0, "R3");
    ins(A(0, 4), 1, 1, 3, 0, 7, 0, "R4");
    lk(A(0, 2), 1, 0, 3, 4, "R2");
    lk(A(0, 4), 1, 0, 7, 1, "R2");
    lk(A(0, 3), 1, 1, 0, 2, "R2");
    do_reset();
    for (int i = 0; i < 4; i++) ins(A(2, 10 + i), 0, 1, 0, 0, i, 0, "R3");
    ins(A(2, 20), 0, 1, 0, 1, 0, 0, "R3");
  endtask

  task automatic t_recency_r5();
    do_reset();
    ins(A(0, 1), 0, 2, 0, 0, 0, 0, "R4");
    ins(A(0, 2), 0, 7, 0, 1, 0, 0, "R4");
    lk(A(0, 1), 1, 0, 0, 2, "R8");
    lk(A(0, 2), 1, 1, 0, 7, "R8");
    ins(A(0, 3), 0, 1, 1, 1, 7, 0, "R5");
    ins(A(0, 4), 0, 2, 1, 0, 2, 0, "R5");
  endtask

  task automatic t_affinity_r6();
    do_reset();
    ins(A(1, 1), 5, 4, 0, 0, 0, 0, "R6");
    ins(A(1, 2), 7, 5, 0, 1, 0, 0, "R6");
    ins(A(1, 3), 7, 2, 2, 1, 5, 0, "R6");
    ins(A(1, 4), 9, 2, 2, 0, 4, 0, "R6");
    lk(A(1, 3), 1, 1, 5, 2, "R6");
  endtask

  task automatic t_evict_r7();
    do_reset();
    for (int i = 0; i < 4; i++) ins(A(1, 30 + i), 0, 8, 0, i, 0, 0, "R7");
    lk(A(1, 30), 1, 0, 0, 8, "R8");
    ins(A(1, 40), 0, 3, 0, 1, 0, 1, "R7");
    lk(A(1, 31), 0, 0, 0, 0, "R7");
    lk(A(1, 40), 1, 1, 0, 3, "R7");
    lk(A(1, 30), 1, 0, 0, 8, "R7");
    ins(A(1, 41), 0, 5, 0, 1, 3, 0, "R3");
  endtask

  task automatic t_inv_r9();
    do_reset();
    ins(A(3, 1), 0, 2, 0, 0, 0, 0, "R9");
    ins(A(3, 2), 0, 3, 0, 0, 2, 0, "R9");
    ins(A(3, 3), 0, 1, 0, 0, 5, 0, "R9");
    inv(A(3, 2));
    lk(A(3, 2), 0, 0, 0, 0, "R9");
    lk(A(3, 1), 1, 0, 0, 2, "R9");
    lk(A(3, 3), 1, 0, 5, 1, "R9");
    ins(A(3, 4), 0, 2, 0, 0, 6, 0, "R9");
    inv(A(3, 4));
    ins(A(3, 5), 0, 2, 0, 0, 6, 0, "R9");
    inv(A(3, 99));
    lk(A(3, 5), 1, 0, 6, 2, "R9");
  endtask

  task automatic t_priority_r10();
    do_reset();
    ins(A(2, 1), 0, 2, 0, 0, 0, 0, "R10");
    @(negedge clk);
    ins_valid = 1; ins_addr = A(2, 2); ins_cnt = 1; policy = 0;
    inv_valid = 1; inv_addr = A(2, 1);
    @(negedge clk);
    ins_valid = 0; inv_valid = 0;
    lk(A(2, 1), 1, 0, 0, 2, "R10");
    lk(A(2, 2), 1, 0, 2, 1, "R10");
    ins(A(2, 3), 0, 0, 0, -1, -1, -1, "R10");
    ins(A(2, 4), 0, 9, 0, -1, -1, -1, "R10");
    lk(A(2, 3), 0, 0, 0, 0, "R10");
    lk(A(2, 4), 0, 0, 0, 0, "R10");
    ins(A(2, 5), 0, 1, 0, 0, 3, 0, "R10");
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_r1();
    t_pack_r3_r4();
    t_recency_r5();
    t_affinity_r6();
    t_evict_r7();
    t_inv_r9();
    t_priority_r10();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule